// File: doc/BRIEF.md
# Timed Instruction Queue Dispatcher

This block sits at the head of one functional slice. It holds fetched instruction words in a small queue and releases at most one of them per clock toward the slice. Most words are passed straight through to the dispatch output. Four control opcodes are carried out inside the block and never reach the slice:
- a counted idle delay;
- a re-issue of the last dispatched word, with a fixed gap between issues;
- a park that holds the queue until a barrier release arrives;
- the release itself, sent as a one-cycle pulse to sibling queues.

Every delay is set by the program and none depends on what other logic is doing. A compiler can therefore know the exact cycle of each dispatch. During a long idle delay the slice clock enable is dropped. It is raised again just in time for the next dispatch. Words can be written into the queue while dispatch is running. If the queue ever runs dry while the program is active, the block sets a sticky error, because from that point the schedule can no longer be trusted.

Top module: `iq_dispatcher`

## Requirements
- R1: After a synchronous reset the queue is empty, `issue_valid`, `barrier_out` and `underflow_err` are low, and `slice_clk_en` is high.
- R2: With `run` high, the word at the head of a non-empty queue is consumed on each clock edge. A word whose opcode (bits [31:28]) is not 1, 2, 3 or 4 appears on `issue_word` with `issue_valid` high in the cycle after that edge. Words leave in write order.
- R3: Opcode 1 is a delay, with N in bits [15:0]. It takes one issue slot without dispatching. The following word is consumed N edges later than it would otherwise be, and nothing is dispatched in between. N = 0 adds no delay.
- R4: For a delay with N > 4, `slice_clk_en` is low for exactly N cycles, starting with the delay's own slot. It is high again one cycle before the next dispatch. For N ≤ 4 it stays high.
- R5: Opcode 2 is a repeat, with n in bits [15:8] and d in bits [7:0]. It takes one slot, then re-issues the last dispatched word n times. The first re-issue comes d+1 cycles after the repeat's slot, and each later one comes d+1 cycles after the previous. The next word is consumed one cycle after the last re-issue. n = 0 acts as a one-slot no-op.
- R6: Opcode 3 is a wait. On reaching the head it stays there and nothing is dispatched. When `barrier_in` is high on a later edge, the wait retires on that edge and the next word is consumed on the following edge.
- R7: A `barrier_in` pulse has no effect when the queue is not parked on a wait. This includes the edge on which a wait first reaches the head.
- R8: Opcode 4 is a release. It takes one slot, dispatches nothing, and drives `barrier_out` high for exactly that cycle.
- R9: If `run` is high, the block is ready to consume, and the queue is empty, `underflow_err` is set. It stays set until reset.
- R10: Writes are accepted while dispatch runs, including during a delay. A write while `fetch_full` is high is dropped, and the dropped word is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_we | input | 1 | Write one instruction word into the queue |
| fetch_word | input | 32 | Instruction word to write |
| fetch_full | output | 1 | Queue is full; writes are dropped |
| run | input | 1 | Program active; enables consumption and underflow detection |
| issue_valid | output | 1 | A word is dispatched this cycle |
| issue_word | output | 32 | Dispatched word |
| barrier_in | input | 1 | Broadcast barrier release pulse |
| barrier_out | output | 1 | Release pulse produced by opcode 4 |
| slice_clk_en | output | 1 | Clock enable for the slice |
| underflow_err | output | 1 | Sticky queue-underflow flag |

## Verification
Every output is registered. The effect of the word consumed on edge e is visible in the cycle after that edge. A delay of N pushes the next consumption to edge e+1+N. A repeat puts its re-issues at e+1+d, then every d+1 edges. A wait retires on the first later barrier edge p, and the next word is consumed on edge p+1.

The bench turns each program into a table of expected outputs, indexed by edge, using these rules. It samples on the falling edge after each rising edge. Barrier pulses and queue writes are also placed at scheduled edges. This lets the ignored pulses, the pulse on the wait's arrival edge, and the mid-delay writes each land on a known cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam logic [3:0] OPC_DELAY   = 4'h1;
  localparam logic [3:0] OPC_REPEAT  = 4'h2;
  localparam logic [3:0] OPC_WAIT    = 4'h3;
  localparam logic [3:0] OPC_RELEASE = 4'h4;

  typedef enum logic [2:0] {
    K_FUNC, K_DELAY, K_REPEAT, K_WAIT, K_RELEASE
  } kind_e;

  typedef enum logic [1:0] {
    S_RUN, S_DELAY, S_REP, S_PARK
  } state_e;
endpackage

// File: rtl/iq_fifo.sv
module iq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr;

  assign full  = (cnt == CNT_MAX);
  assign empty = (cnt == '0);
  assign do_wr = wr_en && !full;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({do_wr, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: the dispatcher never consumes from an empty queue
  a_r2_no_underread: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  // R10: a write while full and not reading leaves the queue full
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> full);
endmodule

// File: rtl/iq_decode.sv
module iq_decode
  import iq_pkg::*;
(
  input  logic [3:0]  opc,
  input  logic [15:0] arg,
  output kind_e       kind,
  output logic [15:0] delay_n,
  output logic [7:0]  rep_n,
  output logic [7:0]  rep_d
);
  always_comb begin
    case (opc)
      OPC_DELAY:   kind = K_DELAY;
      OPC_REPEAT:  kind = K_REPEAT;
      OPC_WAIT:    kind = K_WAIT;
      OPC_RELEASE: kind = K_RELEASE;
      default:     kind = K_FUNC;
    endcase
  end

  assign delay_n = arg;
  assign rep_n   = arg[15:8];
  assign rep_d   = arg[7:0];
endmodule

// File: rtl/iq_dispatcher.sv
module iq_dispatcher
  import iq_pkg::*;
#(
  parameter int W       = 32,
  parameter int DEPTH   = 16,
  parameter int GATE_TH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fetch_we,
  input  logic [W-1:0] fetch_word,
  output logic         fetch_full,
  input  logic         run,
  output logic         issue_valid,
  output logic [W-1:0] issue_word,
  input  logic         barrier_in,
  output logic         barrier_out,
  output logic         slice_clk_en,
  output logic         underflow_err
);
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] GATE_LIM = CNT_W'(GATE_TH);

  logic [W-1:0]     head;
  logic             empty, pop;
  kind_e            kind;
  logic [15:0]      delay_n;
  logic [7:0]       rep_n, rep_d;
  state_e           st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rep_left, rep_gap;
  logic [W-1:0]     last_word;
  logic             take;

  iq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(fetch_we), .wr_data(fetch_word),
    .rd_en(pop), .head(head), .full(fetch_full), .empty(empty)
  );

  iq_decode u_dec (
    .opc(head[W-1:W-4]), .arg(head[15:0]), .kind(kind),
    .delay_n(delay_n), .rep_n(rep_n), .rep_d(rep_d)
  );

  assign take = (st == S_RUN) && run && !empty;
  assign pop  = (take && kind != K_WAIT) || (st == S_PARK && barrier_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_RUN;
      cnt           <= '0;
      rep_left      <= '0;
      rep_gap       <= '0;
      last_word     <= '0;
      issue_valid   <= 1'b0;
      issue_word    <= '0;
      barrier_out   <= 1'b0;
      slice_clk_en  <= 1'b1;
      underflow_err <= 1'b0;
    end else begin
      issue_valid <= 1'b0;
      barrier_out <= 1'b0;
      case (st)
        S_RUN: begin
          if (take) begin
            case (kind)
              K_FUNC: begin
                issue_valid <= 1'b1;
                issue_word  <= head;
                last_word   <= head;
              end
              K_DELAY: if (delay_n != '0) begin
                cnt <= delay_n;
                st  <= S_DELAY;
                if (delay_n > GATE_LIM) slice_clk_en <= 1'b0;
              end
              K_REPEAT: if (rep_n != '0) begin
                rep_left <= rep_n;
                rep_gap  <= rep_d;
                cnt      <= {8'b0, rep_d};
                st       <= S_REP;
              end
              K_WAIT:    st <= S_PARK;
              K_RELEASE: barrier_out <= 1'b1;
              default: ;
            endcase
          end else if (run && empty) begin
            underflow_err <= 1'b1;
          end
        end
        S_DELAY: begin
          cnt <= cnt - 1'b1;
          if (cnt == 16'd1) begin
            st           <= S_RUN;
            slice_clk_en <= 1'b1;
          end
        end
        S_REP: begin
          if (cnt == '0) begin
            issue_valid <= 1'b1;
            issue_word  <= last_word;
            cnt         <= {8'b0, rep_gap};
            rep_left    <= rep_left - 1'b1;
            if (rep_left == 8'd1) st <= S_RUN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PARK: if (barrier_in) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  // R3: nothing is dispatched while a delay counts down
  a_r3_delay_silent: assert property (@(posedge clk) disable iff (rst)
    (st == S_DELAY) |=> !issue_valid);
  // R4: no dispatch while the slice clock is gated
  a_r4_gated_idle: assert property (@(posedge clk) disable iff (rst)
    !slice_clk_en |-> !issue_valid);
  // R5: a due re-issue carries the last dispatched word
  a_r5_reissue_word: assert property (@(posedge clk) disable iff (rst)
    (st == S_REP && cnt == '0) |=> (issue_valid && issue_word == $past(last_word)));
  // R6: a parked queue stays parked and silent without a release
  a_r6_park_hold: assert property (@(posedge clk) disable iff (rst)
    (st == S_PARK && !barrier_in) |=> (st == S_PARK && !issue_valid));
  // R9: the underflow flag is sticky
  a_r9_sticky_err: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);
endmodule

// File: tb/tb_iq_dispatcher.sv
`timescale 1ns/1ps
module tb_iq_dispatcher;
  localparam int NE = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_we = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        fetch_full;
  logic        run = 1'b0;
  logic        issue_valid;
  logic [31:0] issue_word;
  logic        barrier_in = 1'b0;
  logic        barrier_out;
  logic        slice_clk_en;
  logic        underflow_err;

  int checks = 0;
  int fails  = 0;

  // program and expected trace, indexed by edge since run rose
  logic [31:0] prog [32];
  int          plen;
  int          npre;                 // words preloaded before run
  int          app_at [32];          // edge at which word i is written (appended ones)
  logic        bpulse [NE];
  logic        ev [NE];
  logic [31:0] ew [NE];
  logic        eb [NE];
  logic        eck [NE];
  int          etag [NE];
  int          err_from;

  iq_dispatcher dut (
    .clk(clk), .rst(rst), .fetch_we(fetch_we), .fetch_word(fetch_word),
    .fetch_full(fetch_full), .run(run), .issue_valid(issue_valid),
    .issue_word(issue_word), .barrier_in(barrier_in), .barrier_out(barrier_out),
    .slice_clk_en(slice_clk_en), .underflow_err(underflow_err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] w_delay(input int n);
    return {4'h1, 12'h0, n[15:0]};
  endfunction
  function automatic logic [31:0] w_rep(input int n, input int d);
    return {4'h2, 12'h0, n[7:0], d[7:0]};
  endfunction

  // Expected schedule built from the timing rules of R2..R9
  task automatic build_model();
    int slot;
    logic [31:0] last;
    slot = 0;
    last = '0;
    for (int e = 0; e < NE; e++) begin
      ev[e] = 1'b0; ew[e] = '0; eb[e] = 1'b0; eck[e] = 1'b1; etag[e] = 2;
    end
    for (int i = 0; i < plen; i++) begin
      logic [31:0] w;
      w = prog[i];
      case (w[31:28])
        4'h1: begin   // R3 / R4
          int n;
          n = int'(w[15:0]);
          for (int c = slot; c < slot + 1 + n; c++) etag[c] = 3;
          if (n > 4) for (int c = slot; c < slot + n; c++) eck[c] = 1'b0;
          slot = slot + 1 + n;
        end
        4'h2: begin   // R5
          int n, d;
          n = int'(w[15:8]);
          d = int'(w[7:0]);
          slot++;
          for (int j = 0; j < n; j++) begin
            slot = slot + d;
            ev[slot] = 1'b1; ew[slot] = last; etag[slot] = 5;
            slot++;
          end
        end
        4'h3: begin   // R6 / R7: first pulse strictly after the arrival edge
          int p;
          p = -1;
          for (int e = NE - 1; e > slot; e--) if (bpulse[e]) p = e;
          for (int c = slot; c <= p + 1; c++) etag[c] = 6;
          slot = p + 1;
        end
        4'h4: begin   // R8
          eb[slot] = 1'b1;
          slot++;
        end
        default: begin // R2
          ev[slot] = 1'b1; ew[slot] = w; last = w;
          slot++;
        end
      endcase
    end
    err_from = slot;  // R9
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; fetch_we = 1'b0; barrier_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: state straight after reset
    chk(1, {31'b0, issue_valid},   32'd0, "issue_valid after reset");
    chk(1, {31'b0, barrier_out},   32'd0, "barrier_out after reset");
    chk(1, {31'b0, underflow_err}, 32'd0, "underflow_err after reset");
    chk(1, {31'b0, slice_clk_en},  32'd1, "slice_clk_en after reset");
    chk(1, {31'b0, fetch_full},    32'd0, "fetch_full after reset");
  endtask

  task automatic preload(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_we = 1'b1; fetch_word = prog[i];
      @(negedge clk);
    end
    fetch_we = 1'b0;
  endtask

  task automatic run_and_compare(input int len);
    int nxt;
    nxt = npre;
    run = 1'b1;
    for (int e = 0; e < len; e++) begin
      barrier_in = bpulse[e];
      fetch_we = 1'b0;
      if (nxt < plen && app_at[nxt] == e) begin   // R10: write during execution
        fetch_we = 1'b1; fetch_word = prog[nxt]; nxt++;
      end
      @(posedge clk);
      @(negedge clk);
      chk(etag[e], {31'b0, issue_valid}, {31'b0, ev[e]}, $sformatf("issue_valid edge %0d", e));
      if (ev[e]) chk(etag[e], issue_word, ew[e], $sformatf("issue_word edge %0d", e));
      chk(4, {31'b0, slice_clk_en}, {31'b0, eck[e]}, $sformatf("slice_clk_en edge %0d", e));
      chk(8, {31'b0, barrier_out}, {31'b0, eb[e]}, $sformatf("barrier_out edge %0d", e));
      chk(9, {31'b0, underflow_err}, {31'b0, (e >= err_from)}, $sformatf("underflow_err edge %0d", e));
    end
    barrier_in = 1'b0; fetch_we = 1'b0; run = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < NE; e++) bpulse[e] = 1'b0;
    for (int i = 0; i < 32; i++) app_at[i] = -1;

    // Phase 1: mixed program (R2, R3, R5, R6, R7, R8, R9)
    do_reset();
    prog[0]  = 32'hA000_0001;
    prog[1]  = 32'hA000_0002;
    prog[2]  = w_delay(3);          // R3 short delay, no gating
    prog[3]  = 32'hA000_0003;
    prog[4]  = w_rep(2, 1);         // R5
    prog[5]  = 32'hB000_0004;
    prog[6]  = w_rep(1, 0);         // R5 zero gap
    prog[7]  = 32'h4000_0000;       // R8 release
    prog[8]  = 32'h3000_0000;       // R6 wait
    prog[9]  = 32'hC000_0005;
    prog[10] = w_delay(6);          // R4 gated delay
    prog[11] = 32'hC000_0006;
    prog[12] = w_rep(0, 7);         // R5 n = 0
    prog[13] = 32'hC000_0007;
    plen = 14; npre = 14;
    bpulse[2]  = 1'b1;              // R7 ignored: not parked
    bpulse[16] = 1'b1;              // R7 ignored: wait arrives on this edge
    bpulse[20] = 1'b1;              // R6 release
    bpulse[35] = 1'b1;              // R7 ignored after program
    build_model();
    preload(npre);
    run_and_compare(40);

    // Phase 2: long gated delay with words fetched during it (R4, R10)
    for (int e = 0; e < NE; e++) bpulse[e] = 1'b0;
    do_reset();
    prog[0] = w_delay(20);
    prog[1] = 32'hD000_0011;
    prog[2] = 32'hD000_0022;
    plen = 3; npre = 1;
    app_at[1] = 3; app_at[2] = 5;
    build_model();
    preload(npre);
    run_and_compare(28);
    for (int i = 0; i < 32; i++) app_at[i] = -1;

    // Phase 3: overfilled queue; extra write dropped (R10), then underflow (R9)
    do_reset();
    for (int i = 0; i < 17; i++) prog[i] = 32'hE000_0000 + i;
    preload(16);
    chk(10, {31'b0, fetch_full}, 32'd1, "fetch_full after 16 writes");
    prog[16] = 32'hE000_0010;
    fetch_we = 1'b1; fetch_word = prog[16];
    @(negedge clk);
    fetch_we = 1'b0;
    plen = 16; npre = 16;
    build_model();
    run_and_compare(22);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule